// File: doc/BRIEF.md
# Vectored Interrupt Entry Sequencer

This block carries out the entry into and the return from an interrupt handler for a small 16-bit core that uses segment:offset addressing. When it is idle, it samples a set of request lines and picks one of them. For an entry, it saves the flag word, the code segment and the instruction pointer on the memory stack. It then clears the interrupt-enable and trap flags and loads the new code segment and instruction pointer from a vector table that starts at physical address zero. For a return, it pops the three saved words back off the stack.

The core hands over its register values on the `*In` ports. The block latches them when it accepts a request and works on its own copies from then on. When `done` pulses, the `*Out` ports hold the new register state and the core loads it. The memory port moves 16-bit words at 20-bit physical byte addresses. A read returns its data one cycle after it is issued.

Top module: `vectored_int_seq`

## Requirements
- R1: An entry writes the flag word to SS:SP-2, the code segment to SS:SP-4 and the instruction pointer to SS:SP-6, in that order. `spOut` is SP-6 at `done`. A physical address is segment*16 + offset, taken modulo 2^20.
- R2: The pushed flag word is the value the core presented. After an entry, `flagsOut` equals that value with bit 9 (IF) and bit 8 (TF) cleared and all other bits kept.
- R3: After an entry, `ipOut` is the word read from physical address 4*type and `csOut` is the word read from 4*type+2.
- R4: `swReq` enters the handler for any of the 256 types given on `swType`. `bkptReq` enters the handler for type 3.
- R5: `nmiReq` enters the handler for type 2, whose vector is at address 0008h, whatever the value of IF.
- R6: `intrReq` is taken only when IF (bit 9 of `flagsIn`) is 1, and it uses `intrType` as the type. `intrAck` pulses for exactly one cycle, in the cycle the request is accepted. When IF is 0 the request is ignored: there is no memory write, no `done` and no acknowledge.
- R7: `instrEnd`, while TF (bit 8 of `flagsIn`) is 1, starts a single-step entry for type 1. When TF is 0, `instrEnd` has no effect.
- R8: When several requests are present together, the one taken follows this order: software, then breakpoint, then return, then NMI, then maskable, then single-step.
- R9: A return reads the instruction pointer from SS:SP, the code segment from SS:SP+2 and the flag word from SS:SP+4. `spOut` is SP+6 at `done`, and `flagsOut` is the popped word unchanged.
- R10: `busy` is high from the cycle after acceptance until `done` inclusive. `done` lasts one cycle. The block never reads and writes memory in the same cycle, and it ignores requests while it is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| swReq | input | 1 | Software interrupt request |
| swType | input | 8 | Type number for a software interrupt |
| bkptReq | input | 1 | Breakpoint request (type 3) |
| retReq | input | 1 | Return-from-interrupt request |
| nmiReq | input | 1 | Non-maskable request (type 2) |
| intrReq | input | 1 | Maskable request |
| intrType | input | 8 | Type number for the maskable request |
| intrAck | output | 1 | One-cycle acknowledge to the maskable source |
| instrEnd | input | 1 | Instruction boundary; single-step is raised when TF is set |
| flagsIn | input | 16 | Current flag word |
| csIn | input | 16 | Current code segment |
| ipIn | input | 16 | Current instruction pointer |
| ssIn | input | 16 | Current stack segment |
| spIn | input | 16 | Current stack pointer |
| flagsOut | output | 16 | New flag word, valid at `done` |
| csOut | output | 16 | New code segment, valid at `done` |
| ipOut | output | 16 | New instruction pointer, valid at `done` |
| spOut | output | 16 | New stack pointer, valid at `done` |
| memAddr | output | 20 | Physical byte address of the word access |
| memWrData | output | 16 | Write data |
| memWe | output | 1 | Word write strobe |
| memRe | output | 1 | Word read strobe; data is returned on the next cycle |
| memRdData | input | 16 | Read data |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | Sequence complete; outputs hold the new register state |

## Verification
The checks on stack pointer and flags assume three things about the inputs. The register inputs stay stable in the cycle a request is accepted. The memory returns read data on the cycle after `memRe`. The stack pointer is even and at least 6 for an entry. The bench drives all inputs on the falling edge and holds each request for exactly one accepting edge. It picks stack pointers in an even window well away from both zero and the vector table. Its memory model answers every read in exactly one cycle.

// File: rtl/vecseq_pkg.sv
package vecseq_pkg;
  parameter int WORD_W = 16;
  parameter int ADDR_W = 20;
  parameter int TYPE_W = 8;
  localparam int SEG_SHIFT = 4;
  localparam int WORD_BYTES = WORD_W / 8;
  localparam int VEC_SHIFT = 2;
  localparam int IF_BIT = 9;
  localparam int TF_BIT = 8;

  localparam logic [TYPE_W-1:0] TYPE_STEP = TYPE_W'(1);
  localparam logic [TYPE_W-1:0] TYPE_NMI  = TYPE_W'(2);
  localparam logic [TYPE_W-1:0] TYPE_BKPT = TYPE_W'(3);

  typedef enum logic [1:0] {WR_NONE, WR_FLAGS, WR_CS, WR_IP} wrSel_e;

  typedef enum logic [3:0] {
    S_IDLE, S_PF, S_PC, S_PI, S_VL, S_VH, S_VW,
    S_RI, S_RC, S_RF, S_RW, S_DONE
  } seqState_e;

  typedef struct packed {
    logic   latch;
    logic   spDec;
    logic   spInc;
    wrSel_e wrSel;
    logic   memRe;
    logic   useVec;
    logic   vecHi;
    logic   capIp;
    logic   capCs;
    logic   capFlags;
    logic   clrIfTf;
  } seqStrobe_t;
endpackage

// File: rtl/vecseq_ctrl.sv
module vecseq_ctrl
  import vecseq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              swReq,
  input  logic [TYPE_W-1:0] swType,
  input  logic              bkptReq,
  input  logic              retReq,
  input  logic              nmiReq,
  input  logic              intrReq,
  input  logic [TYPE_W-1:0] intrType,
  input  logic              instrEnd,
  input  logic              ifFlag,
  input  logic              tfFlag,
  output seqStrobe_t        strobe,
  output logic [TYPE_W-1:0] typeSel,
  output logic              intrAck,
  output logic              busy,
  output logic              done
);
  seqState_e state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    strobe    = '0;
    typeSel   = '0;
    intrAck   = 1'b0;
    nextState = state;
    unique case (state)
      S_IDLE: begin
        // fixed priority: software, breakpoint, return, NMI, maskable, step
        if (swReq) begin
          typeSel = swType;    nextState = S_PF;
        end else if (bkptReq) begin
          typeSel = TYPE_BKPT; nextState = S_PF;
        end else if (retReq) begin
          nextState = S_RI;
        end else if (nmiReq) begin
          typeSel = TYPE_NMI;  nextState = S_PF;
        end else if (intrReq && ifFlag) begin
          typeSel = intrType;  intrAck = 1'b1; nextState = S_PF;
        end else if (instrEnd && tfFlag) begin
          typeSel = TYPE_STEP; nextState = S_PF;
        end
        strobe.latch = (nextState != S_IDLE);
      end
      S_PF: begin
        strobe.spDec = 1'b1; strobe.wrSel = WR_FLAGS; strobe.clrIfTf = 1'b1;
        nextState = S_PC;
      end
      S_PC: begin
        strobe.spDec = 1'b1; strobe.wrSel = WR_CS; nextState = S_PI;
      end
      S_PI: begin
        strobe.spDec = 1'b1; strobe.wrSel = WR_IP; nextState = S_VL;
      end
      S_VL: begin
        strobe.memRe = 1'b1; strobe.useVec = 1'b1; nextState = S_VH;
      end
      S_VH: begin
        strobe.memRe = 1'b1; strobe.useVec = 1'b1; strobe.vecHi = 1'b1;
        strobe.capIp = 1'b1; nextState = S_VW;
      end
      S_VW: begin
        strobe.capCs = 1'b1; nextState = S_DONE;
      end
      S_RI: begin
        strobe.memRe = 1'b1; strobe.spInc = 1'b1; nextState = S_RC;
      end
      S_RC: begin
        strobe.capIp = 1'b1; strobe.memRe = 1'b1; strobe.spInc = 1'b1;
        nextState = S_RF;
      end
      S_RF: begin
        strobe.capCs = 1'b1; strobe.memRe = 1'b1; strobe.spInc = 1'b1;
        nextState = S_RW;
      end
      S_RW: begin
        strobe.capFlags = 1'b1; nextState = S_DONE;
      end
      S_DONE:  nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  assign busy = (state != S_IDLE);
  assign done = (state == S_DONE);
endmodule

// File: rtl/vecseq_dp.sv
module vecseq_dp
  import vecseq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [TYPE_W-1:0] typeSel,
  input  logic [WORD_W-1:0] flagsIn,
  input  logic [WORD_W-1:0] csIn,
  input  logic [WORD_W-1:0] ipIn,
  input  logic [WORD_W-1:0] ssIn,
  input  logic [WORD_W-1:0] spIn,
  input  logic [WORD_W-1:0] memRdData,
  output logic [WORD_W-1:0] flagsOut,
  output logic [WORD_W-1:0] csOut,
  output logic [WORD_W-1:0] ipOut,
  output logic [WORD_W-1:0] spOut,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWrData,
  output logic              memWe,
  output logic              memRe
);
  logic [WORD_W-1:0] flagsR, csR, ipR, ssR, spR;
  logic [TYPE_W-1:0] typeR;
  logic [WORD_W-1:0] stackOff;
  logic [ADDR_W-1:0] stackAddr, vecAddr;

  assign stackOff  = strobe.spDec ? spR - WORD_W'(WORD_BYTES) : spR;
  assign stackAddr = (ADDR_W'(ssR) << SEG_SHIFT) + ADDR_W'(stackOff);
  assign vecAddr   = (ADDR_W'(typeR) << VEC_SHIFT)
                   + (strobe.vecHi ? ADDR_W'(WORD_BYTES) : '0);
  assign memAddr   = strobe.useVec ? vecAddr : stackAddr;
  assign memWe     = (strobe.wrSel != WR_NONE);
  assign memRe     = strobe.memRe;

  always_comb begin
    unique case (strobe.wrSel)
      WR_FLAGS: memWrData = flagsR;
      WR_CS:    memWrData = csR;
      WR_IP:    memWrData = ipR;
      default:  memWrData = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagsR <= '0; csR <= '0; ipR <= '0;
      ssR <= '0; spR <= '0; typeR <= '0;
    end else begin
      if (strobe.latch) begin
        flagsR <= flagsIn; csR <= csIn; ipR <= ipIn;
        ssR <= ssIn; spR <= spIn; typeR <= typeSel;
      end
      if (strobe.spDec) spR <= stackOff;
      if (strobe.spInc) spR <= spR + WORD_W'(WORD_BYTES);
      if (strobe.clrIfTf) begin
        flagsR[IF_BIT] <= 1'b0;
        flagsR[TF_BIT] <= 1'b0;
      end
      if (strobe.capIp)    ipR    <= memRdData;
      if (strobe.capCs)    csR    <= memRdData;
      if (strobe.capFlags) flagsR <= memRdData;
    end
  end

  assign flagsOut = flagsR;
  assign csOut    = csR;
  assign ipOut    = ipR;
  assign spOut    = spR;
endmodule

// File: rtl/vectored_int_seq.sv
module vectored_int_seq
  import vecseq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              swReq,
  input  logic [TYPE_W-1:0] swType,
  input  logic              bkptReq,
  input  logic              retReq,
  input  logic              nmiReq,
  input  logic              intrReq,
  input  logic [TYPE_W-1:0] intrType,
  output logic              intrAck,
  input  logic              instrEnd,
  input  logic [WORD_W-1:0] flagsIn,
  input  logic [WORD_W-1:0] csIn,
  input  logic [WORD_W-1:0] ipIn,
  input  logic [WORD_W-1:0] ssIn,
  input  logic [WORD_W-1:0] spIn,
  output logic [WORD_W-1:0] flagsOut,
  output logic [WORD_W-1:0] csOut,
  output logic [WORD_W-1:0] ipOut,
  output logic [WORD_W-1:0] spOut,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWrData,
  output logic              memWe,
  output logic              memRe,
  input  logic [WORD_W-1:0] memRdData,
  output logic              busy,
  output logic              done
);
  seqStrobe_t        strobe;
  logic [TYPE_W-1:0] typeSel;

  vecseq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .swReq(swReq), .swType(swType), .bkptReq(bkptReq), .retReq(retReq),
    .nmiReq(nmiReq), .intrReq(intrReq), .intrType(intrType),
    .instrEnd(instrEnd), .ifFlag(flagsIn[IF_BIT]), .tfFlag(flagsIn[TF_BIT]),
    .strobe(strobe), .typeSel(typeSel), .intrAck(intrAck),
    .busy(busy), .done(done)
  );

  vecseq_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .typeSel(typeSel),
    .flagsIn(flagsIn), .csIn(csIn), .ipIn(ipIn), .ssIn(ssIn), .spIn(spIn),
    .memRdData(memRdData),
    .flagsOut(flagsOut), .csOut(csOut), .ipOut(ipOut), .spOut(spOut),
    .memAddr(memAddr), .memWrData(memWrData), .memWe(memWe), .memRe(memRe)
  );
endmodule

// File: rtl/vecseq_check.sv
module vecseq_check (
  input logic        clk,
  input logic        rstN,
  input logic        busy,
  input logic        done,
  input logic        memWe,
  input logic        memRe,
  input logic        intrAck,
  input logic [15:0] spIn,
  input logic [15:0] spOut,
  input logic [15:0] flagsOut
);
  logic [15:0] spStart;
  logic        sawWrite;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      spStart  <= '0;
      sawWrite <= 1'b0;
    end else begin
      if (!busy) spStart <= spIn;
      if (done)       sawWrite <= 1'b0;
      else if (memWe) sawWrite <= 1'b1;
    end
  end

  assert_entry_sp_R1: assert property (@(posedge clk) disable iff (!rstN)
    (done && sawWrite) |-> (spOut == spStart - 16'd6));
  assert_entry_flags_R2: assert property (@(posedge clk) disable iff (!rstN)
    (done && sawWrite) |-> (flagsOut[9:8] == 2'b00));
  assert_ack_starts_R6: assert property (@(posedge clk) disable iff (!rstN)
    intrAck |=> busy);
  assert_ret_sp_R9: assert property (@(posedge clk) disable iff (!rstN)
    (done && !sawWrite) |-> (spOut == spStart + 16'd6));
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  assert_mem_excl_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(memWe && memRe));
  assert_write_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> busy);
endmodule

bind vectored_int_seq vecseq_check u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done), .memWe(memWe),
  .memRe(memRe), .intrAck(intrAck), .spIn(spIn), .spOut(spOut),
  .flagsOut(flagsOut)
);

// File: tb/vectored_int_seq_test.sv
`timescale 1ns/1ps
module vectored_int_seq_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN, swReq, bkptReq, retReq, nmiReq, intrReq, instrEnd, intrAck;
  logic [7:0] swType, intrType;
  logic [15:0] flagsIn, csIn, ipIn, ssIn, spIn;
  logic [15:0] flagsOut, csOut, ipOut, spOut, memWrData, memRdData;
  logic [19:0] memAddr;
  logic memWe, memRe, busy, done;

  int checks = 0;
  int errors = 0;
  int ackCnt = 0;
  int wrCnt = 0;
  int doneCnt = 0;

  logic [15:0] mem [0:4095];
  logic        tbWe = 1'b0;
  logic [11:0] tbIdx = '0;
  logic [15:0] tbData = '0;

  localparam logic [15:0] SS = 16'h0100;

  vectored_int_seq uut (.*);

  always @(posedge clk) begin
    if (tbWe) mem[tbIdx] <= tbData;
    if (memWe) mem[memAddr[12:1]] <= memWrData;
    if (memRe) memRdData <= mem[memAddr[12:1]];
    if (intrAck) ackCnt <= ackCnt + 1;
    if (memWe) wrCnt <= wrCnt + 1;
    if (done) doneCnt <= doneCnt + 1;
  end

  function automatic logic [11:0] sIdx(input logic [15:0] off);
    logic [19:0] a;
    a = {SS, 4'b0} + {4'b0, off};
    return a[12:1];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clearReqs();
    swReq = 0; bkptReq = 0; retReq = 0; nmiReq = 0; intrReq = 0; instrEnd = 0;
  endtask

  task automatic poke(input logic [11:0] idx, input logic [15:0] d);
    tbIdx = idx; tbData = d; tbWe = 1'b1;
    @(negedge clk);
    tbWe = 1'b0;
  endtask

  task automatic waitDone(input string req);
    int n;
    n = 0;
    while (!done && n < 40) begin @(negedge clk); n++; end
    chk({req, " done seen"}, {31'b0, done}, 32'd1);
  endtask

  task automatic setRegs(input logic [15:0] f, c, i, sp);
    flagsIn = f; csIn = c; ipIn = i; spIn = sp; ssIn = SS;
  endtask

  // checks the state after an entry whose request was just accepted
  task automatic expectEntry(input string req, input int t,
                             input logic [15:0] f, c, i, sp);
    waitDone(req);
    chk({req, " ip from vector (R3)"}, {16'b0, ipOut}, {16'b0, 16'hA000 ^ 16'(t)});
    chk({req, " cs from vector (R3)"}, {16'b0, csOut}, {16'b0, 16'hC000 + 16'(t)});
    chk({req, " sp (R1)"}, {16'b0, spOut}, {16'b0, sp - 16'd6});
    chk({req, " flags IF TF clear (R2)"}, {16'b0, flagsOut}, {16'b0, f & 16'hFCFF});
    chk({req, " pushed flags (R1 R2)"}, {16'b0, mem[sIdx(sp - 16'd2)]}, {16'b0, f});
    chk({req, " pushed cs (R1)"}, {16'b0, mem[sIdx(sp - 16'd4)]}, {16'b0, c});
    chk({req, " pushed ip (R1)"}, {16'b0, mem[sIdx(sp - 16'd6)]}, {16'b0, i});
    @(negedge clk);
    chk({req, " done one cycle (R10)"}, {31'b0, done}, 32'd0);
  endtask

  task automatic expectReturn(input string req, input logic [15:0] f, c, i, sp);
    waitDone(req);
    chk({req, " ip popped (R9)"}, {16'b0, ipOut}, {16'b0, i});
    chk({req, " cs popped (R9)"}, {16'b0, csOut}, {16'b0, c});
    chk({req, " flags popped (R9)"}, {16'b0, flagsOut}, {16'b0, f});
    chk({req, " sp (R9)"}, {16'b0, spOut}, {16'b0, sp + 16'd6});
    @(negedge clk);
  endtask

  task automatic preloadFrame(input logic [15:0] f, c, i, sp);
    poke(sIdx(sp), i);
    poke(sIdx(sp + 16'd2), c);
    poke(sIdx(sp + 16'd4), f);
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int a0, w0;
    clearReqs();
    swType = 0; intrType = 0;
    setRegs(16'h0, 16'h0, 16'h0, 16'h0100);
    rstN = 0;
    repeat (3) @(negedge clk);
    chk("reset busy (R10)", {31'b0, busy}, 32'd0);
    chk("reset done (R10)", {31'b0, done}, 32'd0);
    chk("reset memWe (R10)", {31'b0, memWe}, 32'd0);
    chk("reset spOut", {16'b0, spOut}, 32'd0);
    rstN = 1;
    @(negedge clk);
    for (int t = 0; t < 256; t++) begin
      poke(12'(2 * t), 16'hA000 ^ 16'(t));
      poke(12'(2 * t + 1), 16'hC000 + 16'(t));
    end

    // R4: every software type
    for (int t = 0; t < 256; t++) begin
      logic [15:0] f, c, i, sp;
      f = {8'(t) ^ 8'hC3, 8'(t)};
      c = 16'h1000 + 16'(t);
      i = 16'h2000 + 16'(3 * t);
      sp = 16'h0400 + 16'(2 * t);
      setRegs(f, c, i, sp);
      swType = 8'(t); swReq = 1;
      @(negedge clk); clearReqs();
      expectEntry("R4 sw type", t, f, c, i, sp);
    end

    // R4: breakpoint
    setRegs(16'h0302, 16'h1111, 16'h2222, 16'h0300);
    bkptReq = 1; @(negedge clk); clearReqs();
    expectEntry("R4 bkpt", 3, 16'h0302, 16'h1111, 16'h2222, 16'h0300);

    // R5: NMI with IF clear
    setRegs(16'h0044, 16'h3333, 16'h4444, 16'h0320);
    nmiReq = 1; @(negedge clk); clearReqs();
    expectEntry("R5 nmi", 2, 16'h0044, 16'h3333, 16'h4444, 16'h0320);

    // R6: maskable with IF set, ack once
    a0 = ackCnt;
    setRegs(16'h0200, 16'h5555, 16'h6666, 16'h0340);
    intrType = 8'h40; intrReq = 1; @(negedge clk); clearReqs();
    expectEntry("R6 intr", 8'h40, 16'h0200, 16'h5555, 16'h6666, 16'h0340);
    chk("R6 ack pulse count", ackCnt - a0, 32'd1);

    // R6: maskable ignored with IF clear
    a0 = ackCnt; w0 = wrCnt;
    setRegs(16'h0100, 16'h5555, 16'h6666, 16'h0340);
    intrReq = 1;
    repeat (6) @(negedge clk);
    clearReqs();
    chk("R6 masked no busy", {31'b0, busy}, 32'd0);
    chk("R6 masked no ack", ackCnt - a0, 32'd0);
    chk("R6 masked no write", wrCnt - w0, 32'd0);

    // R7: single step taken with TF, ignored without
    setRegs(16'h0100, 16'h7777, 16'h8888, 16'h0360);
    instrEnd = 1; @(negedge clk); clearReqs();
    expectEntry("R7 step", 1, 16'h0100, 16'h7777, 16'h8888, 16'h0360);
    w0 = wrCnt;
    setRegs(16'h0200, 16'h7777, 16'h8888, 16'h0360);
    instrEnd = 1; repeat (4) @(negedge clk); clearReqs();
    chk("R7 no step without TF", wrCnt - w0, 32'd0);
    chk("R7 no step busy", {31'b0, busy}, 32'd0);

    // R8: priority cases
    a0 = ackCnt;
    setRegs(16'h0300, 16'h0A0A, 16'h0B0B, 16'h0380);
    swType = 8'h77; swReq = 1; bkptReq = 1; nmiReq = 1; intrReq = 1; instrEnd = 1;
    @(negedge clk); clearReqs();
    expectEntry("R8 sw over all", 8'h77, 16'h0300, 16'h0A0A, 16'h0B0B, 16'h0380);
    chk("R8 no ack when sw wins", ackCnt - a0, 32'd0);

    setRegs(16'h0300, 16'h0C0C, 16'h0D0D, 16'h03A0);
    bkptReq = 1; retReq = 1; nmiReq = 1;
    @(negedge clk); clearReqs();
    expectEntry("R8 bkpt over ret", 3, 16'h0300, 16'h0C0C, 16'h0D0D, 16'h03A0);

    a0 = ackCnt;
    setRegs(16'h0300, 16'h0E0E, 16'h0F0F, 16'h03C0);
    intrType = 8'h21; nmiReq = 1; intrReq = 1; instrEnd = 1;
    @(negedge clk); clearReqs();
    expectEntry("R8 nmi over intr", 2, 16'h0300, 16'h0E0E, 16'h0F0F, 16'h03C0);
    chk("R8 no ack when nmi wins", ackCnt - a0, 32'd0);

    a0 = ackCnt;
    setRegs(16'h0300, 16'h1212, 16'h1313, 16'h03E0);
    intrType = 8'h22; intrReq = 1; instrEnd = 1;
    @(negedge clk); clearReqs();
    expectEntry("R8 intr over step", 8'h22, 16'h0300, 16'h1212, 16'h1313, 16'h03E0);
    chk("R8 ack when intr wins", ackCnt - a0, 32'd1);

    preloadFrame(16'h0ABC, 16'h1357, 16'h2468, 16'h0500);
    setRegs(16'h0000, 16'h0, 16'h0, 16'h0500);
    retReq = 1; nmiReq = 1; @(negedge clk); clearReqs();
    expectReturn("R8 ret over nmi", 16'h0ABC, 16'h1357, 16'h2468, 16'h0500);

    // R9: return sweep
    for (int k = 0; k < 16; k++) begin
      logic [15:0] f, c, i, sp;
      f = 16'h0F00 ^ 16'(k * 16'h1111);
      c = 16'h4000 + 16'(k);
      i = 16'h5000 + 16'(k * 7);
      sp = 16'h0600 + 16'(k * 8);
      preloadFrame(f, c, i, sp);
      setRegs(16'h0, 16'h0, 16'h0, sp);
      retReq = 1; @(negedge clk); clearReqs();
      expectReturn("R9 return", f, c, i, sp);
    end

    // R10: request while busy is ignored
    w0 = doneCnt;
    setRegs(16'h0200, 16'h9999, 16'hAAAA, 16'h0700);
    swType = 8'h10; swReq = 1; @(negedge clk); clearReqs();
    @(negedge clk);
    nmiReq = 1; @(negedge clk); clearReqs();
    expectEntry("R10 first entry", 8'h10, 16'h0200, 16'h9999, 16'hAAAA, 16'h0700);
    repeat (12) @(negedge clk);
    chk("R10 busy request dropped", doneCnt - w0, 32'd1);
    chk("R10 idle after", {31'b0, busy}, 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule